// File: doc/BRIEF.md
# Three-Wire Configuration Write Port with Deferred Commit

This block receives configuration words over a three-pin write-only serial link (a shift clock, a data line and a latch strobe) and turns them into register updates inside the system clock domain. All three pins are sampled by a faster system clock through two-flop synchronizers, and the block acts on their rising edges. Each frame carries twenty data bits followed by a four-bit register address, both most significant bit first. A rising edge on the latch strobe closes the frame.

Four registers can be written. The function register updates as soon as its frame is latched. Two tuning registers only collect values in a holding area. Their visible copies change when the main tuning register is written, and all three tuning values then become visible together. That same write also emits a single-cycle start pulse, which launches calibration and the fast-lock timer. The pulse is suppressed when the power input is low or when the function register selects the mode with the synthesizer off. A frame whose bit count is anything other than twenty-four at the strobe is dropped. Frames sent to an unused address are dropped too.

Top module: `cfg_serial_port`

## Requirements
- R1: A frame is 24 bits shifted on rising `ser_clk` edges. The first 20 bits are data, bit 19 first. The last 4 bits are the address, bit 3 first. A latched frame to address 1 places its data on `prim_q`.
- R2: If the count of rising `ser_clk` edges since the previous strobe is not exactly 24 when `ser_latch` rises, the frame is discarded. No output changes and no pulse is emitted.
- R3: Frames to address 0 or to addresses 5 through 15 change no output and emit no pulse.
- R4: A frame to address 2 or 3 leaves `aux2_q` and `aux3_q` unchanged. The next frame to address 1 copies the held values to `aux2_q` (from address 2) and `aux3_q` (from address 3).
- R5: A frame to address 4 updates `ctl_q` at once, with no address 1 frame needed.
- R6: A frame to address 1 emits `cal_start` high for exactly one system clock cycle. This happens only when `pwr_on` is high and `ctl_q[3:2]` is not 3.
- R7: A frame to address 1 while `pwr_on` is low, or while `ctl_q[3:2]` equals 3, emits no pulse. It still updates `prim_q`, `aux2_q` and `aux3_q`.
- R8: During and after reset `cal_start` is low and the bit count is empty. After every strobe the count starts again from zero, so a partial frame before reset or before a dropped frame does not disturb the next frame.
- R9: Data is taken at the rising edge of `ser_clk`. Changes on `ser_data` while `ser_clk` stays high have no effect.
- R10: When address 2 or 3 is written more than once before a commit, the most recent value is the one that reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the shift clock rate |
| rst_n | input | 1 | Active-low reset of the framing and pulse logic |
| ser_clk | input | 1 | Asynchronous shift clock pin |
| ser_data | input | 1 | Asynchronous serial data pin |
| ser_latch | input | 1 | Asynchronous latch strobe pin |
| pwr_on | input | 1 | Synthesizer power pin level, synchronous to clk |
| prim_q | output | 20 | Main tuning register (address 1) |
| aux2_q | output | 20 | Committed copy of address 2 |
| aux3_q | output | 20 | Committed copy of address 3 |
| ctl_q | output | 20 | Function register (address 4), mode field in bits 3:2 |
| cal_start | output | 1 | One-cycle calibration and fast-lock start pulse |

## Verification
A bit counter that drifts, or a framing state left over from an earlier frame, shows up at the next strobe. The wrong word lands in a register, or a valid frame is dropped, and the register outputs show it within a few system cycles. A holding register that leaks early shows as `aux2_q` or `aux3_q` changing right after an address 2 or 3 frame, before any commit. A wrong power or mode decision shows as a missing or extra `cal_start` pulse on the address 1 frame itself. The bench therefore compares every output against a reference model after each frame and counts the start pulses.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

    localparam int FRAME_W  = 24;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = FRAME_W - ADDR_W;
    localparam int SYNC_LEN = 2;
    localparam int MODE_LSB = 2;

    localparam logic [ADDR_W-1:0] ADR_PRIM = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_AUX2 = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_AUX3 = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_CTL  = 4'd4;

    localparam logic [1:0] MODE_SYNTH_OFF = 2'd3;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_FULL  = 2'd2,
        FR_OVER  = 2'd3
    } frame_state_e;

    typedef enum logic [1:0] {
        BK_WAIT   = 2'd0,
        BK_STAGE  = 2'd1,
        BK_COMMIT = 2'd2
    } bank_state_e;

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_pin
            logic [STAGES-1:0] chain;
            logic              last;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                    last  <= 1'b0;
                end else begin
                    chain <= {chain[STAGES-2:0], pin_in[g]};
                    last  <= chain[STAGES-1];
                end
            end

            assign level[g] = chain[STAGES-1];
            assign rise[g]  = chain[STAGES-1] & ~last;
        end
    endgenerate

endmodule

// File: rtl/cfg_framer.sv
module cfg_framer
    import cfg_serial_pkg::*;
#(
    parameter int FW = FRAME_W,
    parameter int AW = ADDR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_rise,
    input  logic           bit_val,
    input  logic           strobe_rise,
    output logic           wr_stb,
    output logic [AW-1:0]  wr_addr,
    output logic [FW-AW-1:0] wr_data,
    output frame_state_e   state
);

    localparam int CNT_W = $clog2(FW + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FW - 1);

    frame_state_e      state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [FW-1:0]     shreg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FR_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state: strobe closes any frame; each shift edge advances
    always_comb begin
        state_nx = state;
        if (strobe_rise) begin
            state_nx = FR_IDLE;
        end else if (bit_rise) begin
            unique case (state)
                FR_IDLE:  state_nx = (FW == 1) ? FR_FULL : FR_SHIFT;
                FR_SHIFT: state_nx = (cnt == LAST_CNT) ? FR_FULL : FR_SHIFT;
                FR_FULL:  state_nx = FR_OVER;
                FR_OVER:  state_nx = FR_OVER;
            endcase
        end
    end

    // bit counter and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (strobe_rise) begin
            cnt <= '0;
        end else if (bit_rise) begin
            shreg <= {shreg[FW-2:0], bit_val};
            if (state != FR_OVER) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs: a write leaves only from a complete frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= strobe_rise && (state == FR_FULL);
            if (strobe_rise && (state == FR_FULL)) begin
                wr_addr <= shreg[AW-1:0];
                wr_data <= shreg[FW-1:AW];
            end
        end
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_serial_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int ML = MODE_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          pwr_on,
    output logic [DW-1:0] prim_q,
    output logic [DW-1:0] aux2_q,
    output logic [DW-1:0] aux3_q,
    output logic [DW-1:0] ctl_q,
    output logic          cal_start
);

    bank_state_e   state, state_nx;
    logic [DW-1:0] hold2, hold3;
    logic          synth_up;

    assign synth_up = pwr_on && (ctl_q[ML+1:ML] != MODE_SYNTH_OFF);

    always_comb begin
        state_nx = BK_WAIT;
        if (wr_stb) begin
            unique case (wr_addr)
                ADR_PRIM:           state_nx = BK_COMMIT;
                ADR_AUX2, ADR_AUX3: state_nx = BK_STAGE;
                default:            state_nx = BK_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BK_WAIT;
        end else begin
            state <= state_nx;
        end
    end

    // register contents: left without reset, software writes all four
    always_ff @(posedge clk) begin
        if (wr_stb) begin
            unique case (wr_addr)
                ADR_PRIM: begin
                    prim_q <= wr_data;
                    aux2_q <= hold2;
                    aux3_q <= hold3;
                end
                ADR_AUX2: hold2 <= wr_data;
                ADR_AUX3: hold3 <= wr_data;
                ADR_CTL:  ctl_q <= wr_data;
                default:  ;
            endcase
        end
    end

    // start pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_start <= 1'b0;
        end else begin
            cal_start <= (state_nx == BK_COMMIT) && synth_up;
        end
    end

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfg_serial_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_latch,
    input  logic              pwr_on,
    output logic [DATA_W-1:0] prim_q,
    output logic [DATA_W-1:0] aux2_q,
    output logic [DATA_W-1:0] aux3_q,
    output logic [DATA_W-1:0] ctl_q,
    output logic              cal_start
);

    localparam int PIN_CLK = 0;
    localparam int PIN_DAT = 1;
    localparam int PIN_LAT = 2;

    logic [2:0]        pin_lvl, pin_rise;
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    frame_state_e      fr_state;

    cfg_pin_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_LEN)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in ({ser_latch, ser_data, ser_clk}),
        .level  (pin_lvl),
        .rise   (pin_rise)
    );

    cfg_framer #(
        .FW (FRAME_W),
        .AW (ADDR_W)
    ) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_rise    (pin_rise[PIN_CLK]),
        .bit_val     (pin_lvl[PIN_DAT]),
        .strobe_rise (pin_rise[PIN_LAT]),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .state       (fr_state)
    );

    cfg_reg_bank #(
        .DW (DATA_W),
        .AW (ADDR_W),
        .ML (MODE_LSB)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pwr_on    (pwr_on),
        .prim_q    (prim_q),
        .aux2_q    (aux2_q),
        .aux3_q    (aux3_q),
        .ctl_q     (ctl_q),
        .cal_start (cal_start)
    );

endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk
    import cfg_serial_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              cal_start,
    input  logic [DATA_W-1:0] prim_q,
    input  logic [DATA_W-1:0] aux2_q,
    input  logic [DATA_W-1:0] aux3_q,
    input  logic [DATA_W-1:0] ctl_q,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  frame_state_e      fr_state
);

    AST_STB_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(fr_state == FR_FULL)); // R2

    AST_PRIM_ONLY_ADDR1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prim_q) |-> $past(wr_stb && wr_addr == ADR_PRIM)); // R1

    AST_AUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(aux2_q) || !$stable(aux3_q)) |-> $past(wr_stb && wr_addr == ADR_PRIM)); // R4

    AST_CTL_ONLY_ADDR4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q) |-> $past(wr_stb && wr_addr == ADR_CTL)); // R5

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start); // R6

    AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> $past(wr_stb && wr_addr == ADR_PRIM)); // R6

    AST_PULSE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> $past(pwr_on)); // R7

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!cal_start); // R8
        end
    end

endmodule

bind cfg_serial_port cfg_serial_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_on    (pwr_on),
    .cal_start (cal_start),
    .prim_q    (prim_q),
    .aux2_q    (aux2_q),
    .aux3_q    (aux3_q),
    .ctl_q     (ctl_q),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .fr_state  (fr_state)
);

// File: tb/cfg_serial_port_test.sv
module cfg_serial_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    // each entry: {pwr_on, address[3:0], data[19:0]}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 4'd4, 20'h00010},
        {1'b1, 4'd2, 20'hABCDE},
        {1'b1, 4'd3, 20'h12345},
        {1'b1, 4'd1, 20'h00080},
        {1'b1, 4'd2, 20'h55555},
        {1'b1, 4'd3, 20'hAAAAA},
        {1'b1, 4'd2, 20'h0F0F0},
        {1'b1, 4'd1, 20'hFFFFF},
        {1'b1, 4'd4, 20'h0000C},
        {1'b1, 4'd1, 20'h00001},
        {1'b1, 4'd4, 20'h00004},
        {1'b0, 4'd1, 20'h80000},
        {1'b1, 4'd1, 20'h7FFFE}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_latch = 1'b0;
    logic        pwr_on = 1'b0;
    logic [19:0] prim_q, aux2_q, aux3_q, ctl_q;
    logic        cal_start;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 0;

    logic [19:0] m_prim, m_aux2, m_aux3, m_ctl, m_h2, m_h3;
    int          m_pulses = 0;

    cfg_serial_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_latch (ser_latch),
        .pwr_on    (pwr_on),
        .prim_q    (prim_q),
        .aux2_q    (aux2_q),
        .aux3_q    (aux3_q),
        .ctl_q     (ctl_q),
        .cal_start (cal_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && cal_start) pulses++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] w, input int n, input bit glitch);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = w[i];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            if (glitch) begin
                @(negedge clk);
                ser_data = ~w[i];
                repeat (2) @(negedge clk);
            end else begin
                repeat (3) @(negedge clk);
            end
            ser_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic strobe();
        ser_latch = 1'b1;
        repeat (3) @(negedge clk);
        ser_latch = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic model(input logic p, input logic [3:0] a, input logic [19:0] d);
        case (a)
            4'd1: begin
                m_prim = d; m_aux2 = m_h2; m_aux3 = m_h3;
                if (p && m_ctl[3:2] != 2'd3) m_pulses++;
            end
            4'd2: m_h2 = d;
            4'd3: m_h3 = d;
            4'd4: m_ctl = d;
            default: ;
        endcase
    endtask

    task automatic compare_all(input string tag);
        check({tag, " R1 prim"}, 32'(prim_q), 32'(m_prim));
        check({tag, " R4 aux2"}, 32'(aux2_q), 32'(m_aux2));
        check({tag, " R4 aux3"}, 32'(aux3_q), 32'(m_aux3));
        check({tag, " R5 ctl"},  32'(ctl_q),  32'(m_ctl));
        check({tag, " R6 pulses"}, 32'(pulses), 32'(m_pulses));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R8: quiet during reset
        check("R8 reset pulse", 32'(cal_start), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 after reset pulse", 32'(cal_start), 32'd0);

        // table walk: R1 R4 R5 R6 R7 R10
        for (int v = 0; v < NVEC; v++) begin
            pwr_on = VEC[v][24];
            send_bits({8'd0, VEC[v][19:0], VEC[v][23:20]}, 24, 1'b0);
            strobe();
            model(VEC[v][24], VEC[v][23:20], VEC[v][19:0]);
            if (v >= 3) compare_all($sformatf("vec%0d", v));
            else check("R5 ctl table", 32'(ctl_q), 32'(m_ctl));
        end
        pwr_on = 1'b1;

        // R3: unused addresses
        send_bits({8'd0, 20'h13579, 4'd0}, 24, 1'b0); strobe();
        compare_all("R3 addr0");
        send_bits({8'd0, 20'h2468A, 4'd9}, 24, 1'b0); strobe();
        compare_all("R3 addr9");
        send_bits({8'd0, 20'h11111, 4'd15}, 24, 1'b0); strobe();
        compare_all("R3 addr15");

        // R2: short and long frames to address 1
        send_bits({9'd0, 20'h33333, 3'd1}, 23, 1'b0); strobe();
        compare_all("R2 short");
        send_bits({7'd0, 1'b1, 20'h44444, 4'd1}, 25, 1'b0); strobe();
        compare_all("R2 long");

        // R8: frame right after a dropped one is accepted
        send_bits({8'd0, 20'h00008, 4'd4}, 24, 1'b0); strobe();
        model(1'b1, 4'd4, 20'h00008);
        compare_all("R8 recover");

        // R9: data moves while shift clock is high
        send_bits({8'd0, 20'h0C3A4, 4'd4}, 24, 1'b1); strobe();
        model(1'b1, 4'd4, 20'h0C3A4);
        compare_all("R9 glitch");

        // R8: partial frame, then reset, then a full frame
        send_bits({20'd0, 12'hABC}, 12, 1'b0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 reset mid pulse", 32'(cal_start), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        send_bits({8'd0, 20'h5A5A5, 4'd1}, 24, 1'b0); strobe();
        model(1'b1, 4'd1, 20'h5A5A5);
        compare_all("R8 after reset frame");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule